// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between an interrupt source layer and one processor thread. It keeps a single pending slot: a 24-bit source number with its priority, beside an 8-bit current processor priority and an 8-bit inter-processor-interrupt (IPI) request priority. A level line tells the processor whenever the slot is occupied. Lower numbers are more favoured. The value 0xFF is the least favoured and acts as a mask.

The source layer offers interrupts one at a time. The presenter keeps an offer only when it beats both the current priority and whatever already sits in the slot. Anything that loses is handed back as a reject, whether that is the new offer or the displaced occupant. The IPI competes for the same slot under the reserved source number 2. The processor side has four operations: it writes the current priority, writes the IPI priority, accepts (reads) the pending word, and signals end of interrupt. When the processor opens its window with nothing pending, the block asks the source layer to resend held-back work.

All state and all outputs are registered. An operation applied before a clock edge shows its results on the outputs just after that edge. Notification pulses last one cycle.

Top module: `intr_presenter`

## Requirements
- R1: After reset the output line is low, the pending word (current priority in bits 31:24, source number in bits 23:0) is all zero, and both the pending priority and the IPI priority are 0xFF.
- R2: An accept pulses `acc_valid` for one cycle with `acc_data` = {current priority, source number} as they were before the accept. After it, the current priority takes the old pending priority, the slot is empty (source 0, pending priority 0xFF) and the line is low.
- R3: An offer whose priority is strictly below both the current priority and the pending priority takes the slot and raises the line. If the slot held an external source, that source is rejected in the same result cycle.
- R4: Any other offer is rejected with its own source number, and the slot is left unchanged.
- R5: An IPI priority write always stores the value. Only when the value is below the current priority does the IPI check run. The check takes the slot with source 2 and the IPI priority, unless the slot holds a source whose priority is at or below the IPI priority.
- R6: The reserved number 2 is never reported on the reject port, even when the IPI is displaced or dropped.
- R7: A current-priority write with a value below the old one clears an occupied slot whose pending priority is at or above the new value. The displaced source is rejected and the line drops.
- R8: A current-priority write with a value at or above the old one, made while the slot is empty, issues a resend. The resend pulses `resend_o`, and it runs the IPI check when the IPI priority is below the new current priority.
- R9: An end-of-interrupt write loads bits 31:24 of its data into the current priority and pulses `eoi_valid` with bits 23:0 as `eoi_src`. If the slot is empty, it also issues a resend as in R8.
- R10: When several operations arrive in one cycle, only the first in the order accept, end-of-interrupt, current-priority write, IPI write, offer takes effect. The others are ignored: they cause no reject and leave no state.
- R11: The output line is high exactly when the slot holds a nonzero source number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| offer_valid | input | 1 | Source layer offers an interrupt this cycle |
| offer_src | input | 24 | Offered source number |
| offer_pri | input | 8 | Offered priority |
| cur_pri_wr | input | 1 | Processor writes the current priority |
| cur_pri_data | input | 8 | New current priority |
| ipi_pri_wr | input | 1 | Processor writes the IPI priority |
| ipi_pri_data | input | 8 | New IPI priority |
| accept_req | input | 1 | Processor accepts (reads) the pending word |
| eoi_wr | input | 1 | Processor signals end of interrupt |
| eoi_data | input | 32 | Restored priority (31:24) and finished source (23:0) |
| irq_o | output | 1 | Level interrupt line to the processor |
| acc_valid | output | 1 | Accept result valid |
| acc_data | output | 32 | Pending word returned by accept |
| rej_valid | output | 1 | Reject notification to the source layer |
| rej_src | output | 24 | Rejected source number |
| eoi_valid | output | 1 | End-of-interrupt notification to the source layer |
| eoi_src | output | 24 | Source number being retired |
| resend_o | output | 1 | Request to the source layer to resend held-back work |

## Verification
The checker assumes that offered source numbers are never 0 and never the reserved IPI number. Without this, an empty slot could not be told apart from a real source, and R6 could not hold. The offer and priority-drop properties also assume the operation is the only one in its cycle, so their antecedents demand that all higher-ranked requests are low. The bench keeps every offer to nonzero external numbers. It uses simultaneous requests only in the one deliberate precedence case.

// File: rtl/ip_pkg.sv
package ip_pkg;
   // rank of each operation, lowest index wins a same-cycle collision
   localparam int OPX_ACCEPT = 0;
   localparam int OPX_EOI    = 1;
   localparam int OPX_CURPRI = 2;
   localparam int OPX_IPI    = 3;
   localparam int OPX_OFFER  = 4;
   localparam int OP_COUNT   = 5;

   typedef enum logic [2:0] {
      OPK_NONE,
      OPK_ACCEPT,
      OPK_EOI,
      OPK_CURPRI,
      OPK_IPI,
      OPK_OFFER
   } ip_op_e;
endpackage

// File: rtl/ip_op_select.sv
module ip_op_select #(
   parameter int N = 5
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] grant
);
   logic [N-1:0] busy;

   for (genvar i = 0; i < N; i++) begin : g_rank
      if (i == 0) begin : g_first
         assign busy[i] = 1'b0;
      end else begin : g_next
         assign busy[i] = busy[i-1] | req[i-1];
      end
      assign grant[i] = req[i] & ~busy[i];
   end
endmodule

// File: rtl/ip_ipi_gate.sv
module ip_ipi_gate #(
   parameter int PRI_W   = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2
) (
   input  logic [SRC_W-1:0] slot_src,
   input  logic [PRI_W-1:0] slot_pri,
   input  logic [PRI_W-1:0] ipi_pri,
   input  logic [PRI_W-1:0] thr,
   output logic             fire,
   output logic             evict
);
   localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

   logic occupied, held;

   always_comb begin
      occupied = (slot_src != '0);
      held     = occupied && (slot_pri <= ipi_pri);
      fire     = (ipi_pri < thr) && !held;
      evict    = fire && occupied && (slot_src != IPI_NUM);
   end
endmodule

// File: rtl/ip_offer_judge.sv
module ip_offer_judge #(
   parameter int PRI_W   = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2
) (
   input  logic [PRI_W-1:0] offer_pri,
   input  logic [PRI_W-1:0] cur_pri,
   input  logic [SRC_W-1:0] slot_src,
   input  logic [PRI_W-1:0] slot_pri,
   output logic             win,
   output logic             evict
);
   localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

   always_comb begin
      win   = (offer_pri < cur_pri) && (offer_pri < slot_pri);
      evict = win && (slot_src != '0) && (slot_src != IPI_NUM);
   end
endmodule

// File: rtl/intr_presenter.sv
module intr_presenter #(
   parameter int PRI_W   = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     offer_valid,
   input  logic [SRC_W-1:0]         offer_src,
   input  logic [PRI_W-1:0]         offer_pri,
   input  logic                     cur_pri_wr,
   input  logic [PRI_W-1:0]         cur_pri_data,
   input  logic                     ipi_pri_wr,
   input  logic [PRI_W-1:0]         ipi_pri_data,
   input  logic                     accept_req,
   input  logic                     eoi_wr,
   input  logic [PRI_W+SRC_W-1:0]   eoi_data,
   output logic                     irq_o,
   output logic                     acc_valid,
   output logic [PRI_W+SRC_W-1:0]   acc_data,
   output logic                     rej_valid,
   output logic [SRC_W-1:0]         rej_src,
   output logic                     eoi_valid,
   output logic [SRC_W-1:0]         eoi_src,
   output logic                     resend_o
);
   import ip_pkg::*;

   localparam int               REG_W   = PRI_W + SRC_W;
   localparam logic [PRI_W-1:0] PRI_OFF = '1;
   localparam logic [SRC_W-1:0] IPI_NUM = SRC_W'(IPI_SRC);

   if (PRI_W < 2) begin : g_bad_pri
      $error("intr_presenter: PRI_W must be at least 2");
   end
   if (SRC_W < 2) begin : g_bad_src
      $error("intr_presenter: SRC_W must be at least 2");
   end
   if (IPI_SRC <= 0 || IPI_SRC >= (1 << SRC_W)) begin : g_bad_ipi
      $error("intr_presenter: IPI_SRC must be a nonzero source number");
   end

   // architectural state
   logic [PRI_W-1:0] cppr_q, pend_q, ipi_q;
   logic [SRC_W-1:0] xisr_q;
   logic             irq_q;

   // next state
   logic [PRI_W-1:0] cppr_n, pend_n, ipi_n;
   logic [SRC_W-1:0] xisr_n;
   logic             irq_n;
   logic             acc_v_n, rej_v_n, eoi_v_n, rs_n;
   logic [REG_W-1:0] acc_d_n;
   logic [SRC_W-1:0] rej_s_n, eoi_s_n;

   // operation selection
   logic [OP_COUNT-1:0] op_req, op_grant;
   ip_op_e              op_sel;

   assign op_req[OPX_ACCEPT] = accept_req;
   assign op_req[OPX_EOI]    = eoi_wr;
   assign op_req[OPX_CURPRI] = cur_pri_wr;
   assign op_req[OPX_IPI]    = ipi_pri_wr;
   assign op_req[OPX_OFFER]  = offer_valid;

   ip_op_select #(.N(OP_COUNT)) u_sel (
      .req   (op_req),
      .grant (op_grant)
   );

   always_comb begin
      if (op_grant[OPX_ACCEPT])      op_sel = OPK_ACCEPT;
      else if (op_grant[OPX_EOI])    op_sel = OPK_EOI;
      else if (op_grant[OPX_CURPRI]) op_sel = OPK_CURPRI;
      else if (op_grant[OPX_IPI])    op_sel = OPK_IPI;
      else if (op_grant[OPX_OFFER])  op_sel = OPK_OFFER;
      else                           op_sel = OPK_NONE;
   end

   // IPI gate: priority and threshold depend on which operation runs it
   logic [PRI_W-1:0] gate_ipi, gate_thr;
   logic             gate_fire, gate_evict;

   always_comb begin
      gate_ipi = (op_sel == OPK_IPI) ? ipi_pri_data : ipi_q;
      case (op_sel)
         OPK_IPI: gate_thr = cppr_q;
         OPK_EOI: gate_thr = eoi_data[REG_W-1:SRC_W];
         default: gate_thr = cur_pri_data;
      endcase
   end

   ip_ipi_gate #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_gate (
      .slot_src (xisr_q),
      .slot_pri (pend_q),
      .ipi_pri  (gate_ipi),
      .thr      (gate_thr),
      .fire     (gate_fire),
      .evict    (gate_evict)
   );

   logic judge_win, judge_evict;

   ip_offer_judge #(.PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)) u_judge (
      .offer_pri (offer_pri),
      .cur_pri   (cppr_q),
      .slot_src  (xisr_q),
      .slot_pri  (pend_q),
      .win       (judge_win),
      .evict     (judge_evict)
   );

   logic slot_empty, slot_ext;
   assign slot_empty = (xisr_q == '0);
   assign slot_ext   = !slot_empty && (xisr_q != IPI_NUM);

   always_comb begin
      cppr_n  = cppr_q;
      pend_n  = pend_q;
      ipi_n   = ipi_q;
      xisr_n  = xisr_q;
      irq_n   = irq_q;
      acc_v_n = 1'b0;
      acc_d_n = '0;
      rej_v_n = 1'b0;
      rej_s_n = '0;
      eoi_v_n = 1'b0;
      eoi_s_n = '0;
      rs_n    = 1'b0;

      case (op_sel)
         OPK_ACCEPT: begin
            acc_v_n = 1'b1;
            acc_d_n = {cppr_q, xisr_q};
            cppr_n  = pend_q;
            xisr_n  = '0;
            pend_n  = PRI_OFF;
            irq_n   = 1'b0;
         end
         OPK_EOI: begin
            cppr_n  = eoi_data[REG_W-1:SRC_W];
            eoi_v_n = 1'b1;
            eoi_s_n = eoi_data[SRC_W-1:0];
            if (slot_empty) begin
               rs_n = 1'b1;
               if (gate_fire) begin
                  xisr_n = IPI_NUM;
                  pend_n = ipi_q;
                  irq_n  = 1'b1;
               end
            end
         end
         OPK_CURPRI: begin
            cppr_n = cur_pri_data;
            if (cur_pri_data < cppr_q) begin
               if (!slot_empty && (cur_pri_data <= pend_q)) begin
                  rej_v_n = slot_ext;
                  rej_s_n = slot_ext ? xisr_q : '0;
                  xisr_n  = '0;
                  pend_n  = PRI_OFF;
                  irq_n   = 1'b0;
               end
            end else if (slot_empty) begin
               rs_n = 1'b1;
               if (gate_fire) begin
                  xisr_n = IPI_NUM;
                  pend_n = ipi_q;
                  irq_n  = 1'b1;
               end
            end
         end
         OPK_IPI: begin
            ipi_n = ipi_pri_data;
            if (gate_fire) begin
               rej_v_n = gate_evict;
               rej_s_n = gate_evict ? xisr_q : '0;
               xisr_n  = IPI_NUM;
               pend_n  = ipi_pri_data;
               irq_n   = 1'b1;
            end
         end
         OPK_OFFER: begin
            if (judge_win) begin
               rej_v_n = judge_evict;
               rej_s_n = judge_evict ? xisr_q : '0;
               xisr_n  = offer_src;
               pend_n  = offer_pri;
               irq_n   = 1'b1;
            end else begin
               rej_v_n = 1'b1;
               rej_s_n = offer_src;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cppr_q    <= '0;
         xisr_q    <= '0;
         pend_q    <= PRI_OFF;
         ipi_q     <= PRI_OFF;
         irq_q     <= 1'b0;
         acc_valid <= 1'b0;
         acc_data  <= '0;
         rej_valid <= 1'b0;
         rej_src   <= '0;
         eoi_valid <= 1'b0;
         eoi_src   <= '0;
         resend_o  <= 1'b0;
      end else begin
         cppr_q    <= cppr_n;
         xisr_q    <= xisr_n;
         pend_q    <= pend_n;
         ipi_q     <= ipi_n;
         irq_q     <= irq_n;
         acc_valid <= acc_v_n;
         acc_data  <= acc_d_n;
         rej_valid <= rej_v_n;
         rej_src   <= rej_s_n;
         eoi_valid <= eoi_v_n;
         eoi_src   <= eoi_s_n;
         resend_o  <= rs_n;
      end
   end

   assign irq_o = irq_q;
endmodule

// File: rtl/ip_presenter_chk.sv
module ip_presenter_chk #(
   parameter int PRI_W   = 8,
   parameter int SRC_W   = 24,
   parameter int IPI_SRC = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   offer_valid,
   input logic [SRC_W-1:0]       offer_src,
   input logic [PRI_W-1:0]       offer_pri,
   input logic                   cur_pri_wr,
   input logic [PRI_W-1:0]       cur_pri_data,
   input logic                   ipi_pri_wr,
   input logic                   accept_req,
   input logic                   eoi_wr,
   input logic [PRI_W+SRC_W-1:0] eoi_data,
   input logic                   irq_o,
   input logic                   acc_valid,
   input logic                   rej_valid,
   input logic [SRC_W-1:0]       rej_src,
   input logic                   eoi_valid,
   input logic [SRC_W-1:0]       eoi_src,
   input logic [PRI_W-1:0]       cppr_q,
   input logic [PRI_W-1:0]       pend_q,
   input logic [SRC_W-1:0]       xisr_q
);
   logic offer_alone, cur_alone;
   assign offer_alone = offer_valid && !accept_req && !eoi_wr && !cur_pri_wr && !ipi_pri_wr;
   assign cur_alone   = cur_pri_wr && !accept_req && !eoi_wr;

   p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && xisr_q == '0 && cppr_q == '0 && pend_q == '1));

   p_accept_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
      accept_req |=> (acc_valid && !irq_o));

   p_offer_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (offer_alone && offer_pri < cppr_q && offer_pri < pend_q)
      |=> (irq_o && xisr_q == $past(offer_src)));

   p_offer_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (offer_alone && !(offer_pri < cppr_q && offer_pri < pend_q))
      |=> (rej_valid && rej_src == $past(offer_src)));

   p_no_ipi_reject_r6: assert property (@(posedge clk) disable iff (!rst_n)
      rej_valid |-> (rej_src != SRC_W'(IPI_SRC)));

   p_lower_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_alone && cur_pri_data < cppr_q && xisr_q != '0 && cur_pri_data <= pend_q)
      |=> !irq_o);

   p_eoi_forward_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (eoi_wr && !accept_req)
      |=> (eoi_valid && eoi_src == $past(eoi_data[SRC_W-1:0])));

   p_line_slot_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == (xisr_q != '0));
endmodule

bind intr_presenter ip_presenter_chk #(
   .PRI_W(PRI_W), .SRC_W(SRC_W), .IPI_SRC(IPI_SRC)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .offer_valid  (offer_valid),
   .offer_src    (offer_src),
   .offer_pri    (offer_pri),
   .cur_pri_wr   (cur_pri_wr),
   .cur_pri_data (cur_pri_data),
   .ipi_pri_wr   (ipi_pri_wr),
   .accept_req   (accept_req),
   .eoi_wr       (eoi_wr),
   .eoi_data     (eoi_data),
   .irq_o        (irq_o),
   .acc_valid    (acc_valid),
   .rej_valid    (rej_valid),
   .rej_src      (rej_src),
   .eoi_valid    (eoi_valid),
   .eoi_src      (eoi_src),
   .cppr_q       (cppr_q),
   .pend_q       (pend_q),
   .xisr_q       (xisr_q)
);

// File: tb/test_intr_presenter.sv
module test_intr_presenter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        offer_valid = 1'b0;
   logic [23:0] offer_src = '0;
   logic [7:0]  offer_pri = '0;
   logic        cur_pri_wr = 1'b0;
   logic [7:0]  cur_pri_data = '0;
   logic        ipi_pri_wr = 1'b0;
   logic [7:0]  ipi_pri_data = '0;
   logic        accept_req = 1'b0;
   logic        eoi_wr = 1'b0;
   logic [31:0] eoi_data = '0;
   logic        irq_o, acc_valid, rej_valid, eoi_valid, resend_o;
   logic [31:0] acc_data;
   logic [23:0] rej_src, eoi_src;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   intr_presenter i_intr_presenter (
      .clk, .rst_n, .offer_valid, .offer_src, .offer_pri,
      .cur_pri_wr, .cur_pri_data, .ipi_pri_wr, .ipi_pri_data,
      .accept_req, .eoi_wr, .eoi_data, .irq_o, .acc_valid, .acc_data,
      .rej_valid, .rej_src, .eoi_valid, .eoi_src, .resend_o
   );

   typedef struct {
      logic        irq;
      logic        acc_v;
      logic [31:0] acc_d;
      logic        rej_v;
      logic [23:0] rej_s;
      logic        eoi_v;
      logic [23:0] eoi_s;
      logic        rs;
      string       tag;
   } exp_t;

   exp_t sb[$];

   // reference state built from the requirements
   logic [7:0]  m_cppr = 8'h00, m_pend = 8'hFF, m_ipi = 8'hFF;
   logic [23:0] m_src = '0;

   task automatic drive(input logic acc, input logic eo, input logic [31:0] ed,
                        input logic cw, input logic [7:0] cd,
                        input logic iw, input logic [7:0] id,
                        input logic ov, input logic [23:0] os, input logic [7:0] op,
                        input string tag);
      exp_t e;
      @(negedge clk);
      accept_req = acc; eoi_wr = eo; eoi_data = ed;
      cur_pri_wr = cw; cur_pri_data = cd;
      ipi_pri_wr = iw; ipi_pri_data = id;
      offer_valid = ov; offer_src = os; offer_pri = op;
      e.acc_v = 0; e.acc_d = '0; e.rej_v = 0; e.rej_s = '0;
      e.eoi_v = 0; e.eoi_s = '0; e.rs = 0; e.tag = tag;
      if (acc) begin
         e.acc_v = 1; e.acc_d = {m_cppr, m_src};
         m_cppr = m_pend; m_src = '0; m_pend = 8'hFF;
      end else if (eo) begin
         m_cppr = ed[31:24]; e.eoi_v = 1; e.eoi_s = ed[23:0];
         if (m_src == 0) begin
            e.rs = 1;
            if (m_ipi < m_cppr) begin m_src = 24'd2; m_pend = m_ipi; end
         end
      end else if (cw) begin
         if (cd < m_cppr) begin
            if (m_src != 0 && cd <= m_pend) begin
               if (m_src != 24'd2) begin e.rej_v = 1; e.rej_s = m_src; end
               m_src = '0; m_pend = 8'hFF;
            end
            m_cppr = cd;
         end else begin
            m_cppr = cd;
            if (m_src == 0) begin
               e.rs = 1;
               if (m_ipi < m_cppr) begin m_src = 24'd2; m_pend = m_ipi; end
            end
         end
      end else if (iw) begin
         m_ipi = id;
         if (id < m_cppr && !(m_src != 0 && m_pend <= id)) begin
            if (m_src != 0 && m_src != 24'd2) begin e.rej_v = 1; e.rej_s = m_src; end
            m_src = 24'd2; m_pend = id;
         end
      end else if (ov) begin
         if (op < m_cppr && op < m_pend) begin
            if (m_src != 0 && m_src != 24'd2) begin e.rej_v = 1; e.rej_s = m_src; end
            m_src = os; m_pend = op;
         end else begin
            e.rej_v = 1; e.rej_s = os;
         end
      end
      e.irq = (m_src != 0);
      sb.push_back(e);
   endtask

   task automatic idle(input string tag);
      drive(0, 0, '0, 0, '0, 0, '0, 0, '0, '0, tag);
   endtask
   task automatic do_accept(input string tag);
      drive(1, 0, '0, 0, '0, 0, '0, 0, '0, '0, tag);
   endtask
   task automatic do_offer(input logic [23:0] s, input logic [7:0] p, input string tag);
      drive(0, 0, '0, 0, '0, 0, '0, 1, s, p, tag);
   endtask
   task automatic do_cur(input logic [7:0] v, input string tag);
      drive(0, 0, '0, 1, v, 0, '0, 0, '0, '0, tag);
   endtask
   task automatic do_ipi(input logic [7:0] v, input string tag);
      drive(0, 0, '0, 0, '0, 1, v, 0, '0, '0, tag);
   endtask
   task automatic do_eoi(input logic [31:0] d, input string tag);
      drive(0, 1, d, 0, '0, 0, '0, 0, '0, '0, tag);
   endtask

   // monitor: one expected record per driven cycle
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (irq_o !== e.irq || acc_valid !== e.acc_v ||
                (e.acc_v && acc_data !== e.acc_d) ||
                rej_valid !== e.rej_v || (e.rej_v && rej_src !== e.rej_s) ||
                eoi_valid !== e.eoi_v || (e.eoi_v && eoi_src !== e.eoi_s) ||
                resend_o !== e.rs) begin
               errors++;
               $display("FAIL %s: actual irq=%b acc=%b/%h rej=%b/%h eoi=%b/%h rs=%b expected irq=%b acc=%b/%h rej=%b/%h eoi=%b/%h rs=%b",
                  e.tag, irq_o, acc_valid, acc_data, rej_valid, rej_src, eoi_valid, eoi_src, resend_o,
                  e.irq, e.acc_v, e.acc_d, e.rej_v, e.rej_s, e.eoi_v, e.eoi_s, e.rs);
            end
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 5000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual run still active, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      checks++;
      if (irq_o !== 1'b0 || rej_valid !== 1'b0 || resend_o !== 1'b0) begin
         errors++;
         $display("FAIL R1: actual irq=%b rej=%b rs=%b expected all 0", irq_o, rej_valid, resend_o);
      end
      // R1 and R2: accept right after reset returns an all-zero word, then cppr becomes 0xFF
      do_accept("R1 R2 reset word");
      do_offer(24'h000123, 8'h05, "R3 take empty slot");
      do_offer(24'h000200, 8'h07, "R4 worse offer rejected");
      do_offer(24'h000300, 8'h03, "R3 displace external");
      do_accept("R2 accept pending");
      do_offer(24'h000400, 8'h03, "R4 equal to cppr rejected");
      do_eoi({8'hFF, 24'h000300}, "R9 eoi resend empty slot");
      do_ipi(8'h04, "R5 ipi takes empty slot");
      do_offer(24'h000500, 8'h02, "R6 offer displaces ipi silently");
      do_ipi(8'h01, "R5 ipi displaces external");
      do_ipi(8'h06, "R5 ipi held by better occupant");
      do_cur(8'h01, "R7 R6 lowering drops ipi no reject");
      do_cur(8'h09, "R8 raise empty resend and ipi");
      do_accept("R2 accept ipi");
      do_offer(24'h000600, 8'h05, "R3 take below cppr");
      do_cur(8'h05, "R7 lowering rejects occupant");
      do_cur(8'h04, "R8 lowering empty no resend");
      do_ipi(8'h07, "R5 store without check");
      do_cur(8'h08, "R8 raise uses stored ipi");
      drive(1, 0, '0, 0, '0, 0, '0, 1, 24'h000700, 8'h00, "R10 accept beats offer");
      idle("R10 offer left no trace");
      do_offer(24'h000800, 8'h03, "R3 take");
      do_cur(8'h20, "R8 raise with occupant no resend");
      do_eoi({8'h02, 24'h000ABC}, "R9 eoi with occupant no resend");
      do_accept("R2 R9 accept shows eoi priority");
      drive(0, 1, {8'h30, 24'h000111}, 1, 8'h00, 0, '0, 1, 24'h000900, 8'h01, "R10 eoi beats cur and offer");
      idle("R11 line follows slot");
      idle("R11 tail");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule